// File: doc/BRIEF.md
# Two-Lane FEC Marker Mapper and Symbol Distributor

This block sits on the transmit side of a 100 Gb/s Reed-Solomon FEC sublayer that spreads its codewords over two FEC lanes. It takes an RS(544,514) codeword stream, two 10-bit symbols per beat, and writes each symbol to one of two lane outputs. Codewords are not interleaved. Every `AM_PERIOD` codewords it opens a marker codeword. In that codeword the leading symbol positions are filled from the twenty 64-bit PCS lane markers, followed by a 5-bit pad. The upstream encoder reserves those positions, so their parity is already correct.

The twenty markers are laid out so that each lane carries only its own half. Even-numbered markers land on lane 0 and odd-numbered markers on lane 1, ten per lane, each as a contiguous 64-bit run. The 1280 marker bits fill symbols 0 to 127. The 5 pad bits take the low half of symbol 128, which is lane 0 at beat 64. Scrambled payload follows at once.

Both the symbol input and the lane output are valid/ready streams. A beat moves on a clock edge where valid and ready are both high. The output holds its values for as long as it is stalled. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The marker input is a plain bus. It is sampled on each accepted beat in the first 64 beats of a marker codeword, so it must hold the locked markers over those beats.

Top module: `fec2_am_distrib`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high. The first beat accepted after reset is beat 0 of a marker codeword.
- R2: Codeword symbol k goes to lane k mod 2. On beat j, `lane0_sym` carries `in_sym_even` (symbol 2j) and `lane1_sym` carries `in_sym_odd` (symbol 2j+1), unchanged except in the positions named in R4 to R6.
- R3: A codeword is 272 beats. `lane0_cw_start` and `lane1_cw_start` are both high on beat 0 and low on every other beat.
- R4: In a marker codeword, lane 0 on beat j (j < 64) carries bits 10j to 10j+9 of the 640-bit chain formed by markers 0, 2, ..., 18 in that order. Marker i occupies `am_data[64i+63:64i]`, bit 0 first. Symbol bit b is chain bit 10j+b.
- R5: Lane 1 follows the same rule with markers 1, 3, ..., 19.
- R6: In a marker codeword, on beat 64, `lane0_sym[4:0]` equals `PAD_VALUE` (default 5'h15) and `lane0_sym[9:5]` equals `in_sym_even[9:5]`. `lane1_sym` passes through unchanged.
- R7: `am_cw` is high on every beat of codewords whose index since reset is a multiple of `AM_PERIOD`, and low on every beat of the other codewords. Those other codewords pass every symbol through unchanged.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R9: `am_data` has no effect on any beat other than beats 0 to 63 of a marker codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| am_data | input | 1280 | Twenty 64-bit markers; marker i at bits 64i+63:64i |
| in_valid | input | 1 | Symbol beat offered |
| in_ready | output | 1 | Symbol beat accepted when high with in_valid |
| in_sym_even | input | 10 | Codeword symbol 2j of beat j |
| in_sym_odd | input | 10 | Codeword symbol 2j+1 of beat j |
| out_valid | output | 1 | Lane beat present |
| out_ready | input | 1 | Downstream takes the lane beat |
| lane0_sym | output | 10 | FEC lane 0 symbol |
| lane1_sym | output | 10 | FEC lane 1 symbol |
| lane0_cw_start | output | 1 | Lane 0 codeword start |
| lane1_cw_start | output | 1 | Lane 1 codeword start |
| am_cw | output | 1 | Beat belongs to a marker codeword |

## Verification
The bench probes several boundaries:
- Beat 63 against beat 64 of a marker codeword. A design with an off-by-one marker window would leak marker bits into payload or cut the last symbol short.
- The pad symbol on lane 0. Putting the pad on the wrong lane or in the wrong bits would corrupt payload.
- Every beat on both lanes with twenty distinct markers. This exposes an even/odd swap or a chain laid in the wrong order.
- The wrap from the last codeword in the period back to a marker codeword. An off-by-one period would mark the wrong codeword.

It also changes the marker bus outside the marker window to show it has no effect. It stalls the output every third cycle to catch a lost or repeated beat.

// File: rtl/fec2_pkg.sv
package fec2_pkg;
  localparam int FEC_LANES = 2;

  typedef struct packed {
    logic first;   // beat 0 of a codeword
    logic marker;  // codeword carries the marker group
  } cw_pos_t;
endpackage

// File: rtl/fec2_beat_tracker.sv
module fec2_beat_tracker #(
  parameter int BEATS     = 272,
  parameter int AM_PERIOD = 1024,
  localparam int BW = $clog2(BEATS),
  localparam int CW = $clog2(AM_PERIOD + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  output logic [BW-1:0]        beat_idx,
  output fec2_pkg::cw_pos_t    pos
);
  logic [CW-1:0] cw_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_idx <= '0;
      cw_idx   <= '0;
    end else if (adv) begin
      if (beat_idx == BW'(BEATS - 1)) begin
        beat_idx <= '0;
        cw_idx   <= (cw_idx == CW'(AM_PERIOD - 1)) ? '0 : cw_idx + 1'b1;
      end else begin
        beat_idx <= beat_idx + 1'b1;
      end
    end
  end

  assign pos.first  = (beat_idx == '0);
  assign pos.marker = (cw_idx == '0);
endmodule

// File: rtl/fec2_lane_mapper.sv
module fec2_lane_mapper #(
  parameter int SYM_W     = 10,
  parameter int N_MARKERS = 20,
  parameter int MARKER_W  = 64,
  parameter int PAD_W     = 5,
  parameter logic [PAD_W-1:0] PAD_VALUE = PAD_W'(5'h15),
  parameter int LANES     = 2,
  parameter int LANE      = 0,
  parameter int BW        = 9,
  localparam int MK_PER_LANE = N_MARKERS / LANES,
  localparam int LANE_BITS   = MK_PER_LANE * MARKER_W,
  localparam int MK_BEATS    = LANE_BITS / SYM_W,
  localparam int PAD_SYM     = (N_MARKERS * MARKER_W) / SYM_W,
  localparam int PAD_LANE    = PAD_SYM % LANES,
  localparam int PAD_BEAT    = PAD_SYM / LANES,
  localparam int IW          = $clog2(LANE_BITS)
) (
  input  logic [N_MARKERS*MARKER_W-1:0] am_data,
  input  logic [BW-1:0]                 beat_idx,
  input  logic                          marker_cw,
  input  logic [SYM_W-1:0]              sym_in,
  output logic [SYM_W-1:0]              sym_out
);
  // This lane's markers chained in rising order, bit 0 first
  logic [LANE_BITS-1:0] chain;
  logic [IW-1:0]        base;

  for (genvar m = 0; m < MK_PER_LANE; m++) begin : g_chain
    assign chain[m*MARKER_W +: MARKER_W] = am_data[(m*LANES + LANE)*MARKER_W +: MARKER_W];
  end

  assign base = IW'(beat_idx) * IW'(SYM_W);

  always_comb begin
    sym_out = sym_in;
    if (marker_cw) begin
      if (beat_idx < BW'(MK_BEATS)) begin
        sym_out = chain[base +: SYM_W];
      end else if ((LANE == PAD_LANE) && (beat_idx == BW'(PAD_BEAT))) begin
        sym_out[PAD_W-1:0] = PAD_VALUE;
      end
    end
  end
endmodule

// File: rtl/fec2_lane_stage.sv
module fec2_lane_stage #(
  parameter int SYM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SYM_W-1:0] sym_d,
  input  logic             start_d,
  output logic [SYM_W-1:0] sym_q,
  output logic             start_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_q   <= '0;
      start_q <= 1'b0;
    end else if (load) begin
      sym_q   <= sym_d;
      start_q <= start_d;
    end
  end
endmodule

// File: rtl/fec2_am_distrib.sv
module fec2_am_distrib #(
  parameter int SYM_W     = 10,
  parameter int CW_SYMS   = 544,
  parameter int N_MARKERS = 20,
  parameter int MARKER_W  = 64,
  parameter int PAD_W     = 5,
  parameter logic [PAD_W-1:0] PAD_VALUE = PAD_W'(5'h15),
  parameter int AM_PERIOD = 1024,
  localparam int LANES = fec2_pkg::FEC_LANES,
  localparam int BEATS = CW_SYMS / LANES,
  localparam int BW    = $clog2(BEATS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_MARKERS*MARKER_W-1:0] am_data,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [SYM_W-1:0]              in_sym_even,
  input  logic [SYM_W-1:0]              in_sym_odd,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [SYM_W-1:0]              lane0_sym,
  output logic [SYM_W-1:0]              lane1_sym,
  output logic                          lane0_cw_start,
  output logic                          lane1_cw_start,
  output logic                          am_cw
);
  logic              adv;
  logic [BW-1:0]     beat_idx;
  fec2_pkg::cw_pos_t pos;
  logic [SYM_W-1:0]  in_syms  [LANES];
  logic [SYM_W-1:0]  mapped   [LANES];
  logic [SYM_W-1:0]  lane_q   [LANES];
  logic              start_q  [LANES];

  assign in_ready   = !out_valid || out_ready;
  assign adv        = in_valid && in_ready;
  assign in_syms[0] = in_sym_even;
  assign in_syms[1] = in_sym_odd;

  fec2_beat_tracker #(.BEATS(BEATS), .AM_PERIOD(AM_PERIOD)) u_track (
    .clk(clk), .rst_n(rst_n), .adv(adv), .beat_idx(beat_idx), .pos(pos)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fec2_lane_mapper #(
      .SYM_W(SYM_W), .N_MARKERS(N_MARKERS), .MARKER_W(MARKER_W), .PAD_W(PAD_W),
      .PAD_VALUE(PAD_VALUE), .LANES(LANES), .LANE(l), .BW(BW)
    ) u_map (
      .am_data(am_data), .beat_idx(beat_idx), .marker_cw(pos.marker),
      .sym_in(in_syms[l]), .sym_out(mapped[l])
    );
    fec2_lane_stage #(.SYM_W(SYM_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .load(adv), .sym_d(mapped[l]),
      .start_d(pos.first), .sym_q(lane_q[l]), .start_q(start_q[l])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      am_cw     <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (adv)      am_cw     <= pos.marker;
    end
  end

  assign lane0_sym      = lane_q[0];
  assign lane1_sym      = lane_q[1];
  assign lane0_cw_start = start_q[0];
  assign lane1_cw_start = start_q[1];
endmodule

// File: rtl/fec2_am_distrib_chk.sv
module fec2_am_distrib_chk #(
  parameter int SYM_W = 10,
  parameter int BEATS = 272,
  localparam int BW = $clog2(BEATS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SYM_W-1:0] lane0_sym,
  input logic [SYM_W-1:0] lane1_sym,
  input logic             lane0_cw_start,
  input logic             lane1_cw_start,
  input logic             am_cw
);
  logic [BW-1:0] obeat;
  logic          am_at_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obeat       <= '0;
      am_at_start <= 1'b1;
    end else if (out_valid && out_ready) begin
      obeat <= (obeat == BW'(BEATS - 1)) ? '0 : obeat + 1'b1;
      if (lane0_cw_start) am_at_start <= am_cw;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(lane0_sym) && $stable(lane1_sym)
      && $stable(am_cw) && $stable(lane0_cw_start) && $stable(lane1_cw_start));

  p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_start_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lane0_cw_start == lane1_cw_start);

  p_start_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lane0_cw_start == (obeat == '0)));

  p_am_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !lane0_cw_start |-> am_cw == am_at_start);
endmodule

bind fec2_am_distrib fec2_am_distrib_chk #(.SYM_W(SYM_W), .BEATS(BEATS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .lane0_sym(lane0_sym),
  .lane1_sym(lane1_sym), .lane0_cw_start(lane0_cw_start),
  .lane1_cw_start(lane1_cw_start), .am_cw(am_cw)
);

// File: tb/fec2_am_distrib_tb.sv
`timescale 1ns/100ps
module fec2_am_distrib_tb;
  localparam int PERIOD = 3;
  localparam int NB     = 272;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1279:0] am_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [9:0] in_sym_even = '0;
  logic [9:0] in_sym_odd = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [9:0] lane0_sym, lane1_sym;
  logic lane0_cw_start, lane1_cw_start, am_cw;

  int checks = 0;
  int fails = 0;
  logic [63:0] mk [20];
  logic [9:0] rec_l0 [2048];
  logic [9:0] rec_l1 [2048];
  logic rec_st0 [2048];
  logic rec_st1 [2048];
  logic rec_am [2048];
  int rec_n = 0;
  bit stall_mode = 1'b0;
  int cyc = 0;
  bit prev_stall = 1'b0;
  logic [23:0] prev_vals;

  // {cw, beat, lane0, lane1, start, am}; markers: even all ones, odd all zeros
  localparam logic [33:0] TBL [10] = '{
    {3'd0, 9'd0,   10'h3FF, 10'h000, 1'b1, 1'b1},
    {3'd0, 9'd63,  10'h3FF, 10'h000, 1'b0, 1'b1},
    {3'd0, 9'd64,  10'h095, 10'h081, 1'b0, 1'b1},
    {3'd0, 9'd65,  10'h082, 10'h083, 1'b0, 1'b1},
    {3'd0, 9'd271, 10'h21E, 10'h21F, 1'b0, 1'b1},
    {3'd1, 9'd0,   10'h000, 10'h001, 1'b1, 1'b0},
    {3'd1, 9'd64,  10'h080, 10'h081, 1'b0, 1'b0},
    {3'd2, 9'd10,  10'h014, 10'h015, 1'b0, 1'b0},
    {3'd3, 9'd0,   10'h3FF, 10'h000, 1'b1, 1'b1},
    {3'd3, 9'd64,  10'h095, 10'h081, 1'b0, 1'b1}
  };

  fec2_am_distrib #(.AM_PERIOD(PERIOD)) u_dut (
    .clk(clk), .rst_n(rst_n), .am_data(am_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_sym_even(in_sym_even), .in_sym_odd(in_sym_odd),
    .out_valid(out_valid), .out_ready(out_ready), .lane0_sym(lane0_sym),
    .lane1_sym(lane1_sym), .lane0_cw_start(lane0_cw_start),
    .lane1_cw_start(lane1_cw_start), .am_cw(am_cw)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    out_ready = stall_mode ? ((cyc % 3) != 1) : 1'b1;
  end

  // Monitor: records handshaken beats; checks hold during stalls (R8)
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (prev_stall) begin
        checks++;
        if (!out_valid || prev_vals != {lane0_sym, lane1_sym, lane0_cw_start, lane1_cw_start, am_cw, 1'b0}) begin
          fails++;
          $display("FAIL R8 stalled output moved: actual %h expected %h", {lane0_sym, lane1_sym, lane0_cw_start, lane1_cw_start, am_cw, 1'b0}, prev_vals);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_vals  = {lane0_sym, lane1_sym, lane0_cw_start, lane1_cw_start, am_cw, 1'b0};
      if (out_valid && out_ready && rec_n < 2048) begin
        rec_l0[rec_n] = lane0_sym;
        rec_l1[rec_n] = lane1_sym;
        rec_st0[rec_n] = lane0_cw_start;
        rec_st1[rec_n] = lane1_cw_start;
        rec_am[rec_n] = am_cw;
        rec_n++;
      end
    end else begin
      prev_stall = 1'b0;
    end
  end

  function automatic logic [1279:0] pack_mk();
    logic [1279:0] v;
    for (int i = 0; i < 20; i++) v[64*i +: 64] = mk[i];
    return v;
  endfunction

  function automatic logic [9:0] exp_sym(int lane, int c, int j);
    logic [9:0] s;
    s = 10'(2*j + lane);
    if (c % PERIOD == 0) begin
      if (j < 64) begin
        for (int b = 0; b < 10; b++) begin
          int n;
          n = 10*j + b;
          s[b] = mk[2*(n/64) + lane][n % 64];
        end
      end else if (j == 64 && lane == 0) begin
        s[4:0] = 5'h15;
      end
    end
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rec_n = 0;
  endtask

  // Drives n codewords; toggle flips am_data outside the marker window (R9)
  task automatic run_cws(int n, bit toggle);
    for (int c = 0; c < n; c++) begin
      for (int j = 0; j < NB; j++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_sym_even = 10'(2*j);
        in_sym_odd = 10'(2*j + 1);
        am_data = (toggle && !((c % PERIOD == 0) && j < 64)) ? ~pack_mk() : pack_mk();
        #1;
        while (!in_ready) begin
          @(negedge clk);
          #1;
        end
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic check_all(int ncw, string req);
    check({req, " beat count"}, 32'(rec_n), 32'(ncw*NB));
    for (int k = 0; k < ncw*NB && k < rec_n; k++) begin
      int c, j;
      c = k / NB;
      j = k % NB;
      check(req, {rec_l0[k], rec_l1[k]}, {exp_sym(0, c, j), exp_sym(1, c, j)});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int bad_st, bad_am;
    // Phase A: even markers ones, odd zeros; probe table
    for (int i = 0; i < 20; i++) mk[i] = (i % 2 == 0) ? '1 : '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 out_valid in reset", 32'(out_valid), 32'd0);
    do_reset();
    #1;
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    check("R1 in_ready after reset", 32'(in_ready), 32'd1);
    run_cws(4, 1'b0);
    for (int t = 0; t < 10; t++) begin
      int k;
      k = int'(TBL[t][33:31]) * NB + int'(TBL[t][30:22]);
      check("R2 R4 R5 R6 table lanes", {rec_l0[k], rec_l1[k]}, {TBL[t][21:12], TBL[t][11:2]});
      check("R3 table start", {rec_st0[k], rec_st1[k]}, {TBL[t][1], TBL[t][1]});
      check("R7 table am_cw", 32'(rec_am[k]), 32'(TBL[t][0]));
    end
    bad_st = 0;
    bad_am = 0;
    for (int k = 0; k < rec_n; k++) begin
      if (rec_st0[k] != (k % NB == 0) || rec_st1[k] != (k % NB == 0)) bad_st++;
      if (rec_am[k] != ((k / NB) % PERIOD == 0)) bad_am++;
    end
    check("R3 start flags on every beat", 32'(bad_st), 32'd0);
    check("R7 marker flag on every beat", 32'(bad_am), 32'd0);

    // Phase B: twenty distinct markers; am_data toggled outside window (R4 R5 R6 R9)
    for (int i = 0; i < 20; i++) mk[i] = {8{8'(i*37 + 11)}} ^ (64'(i + 1) << 23);
    do_reset();
    run_cws(2, 1'b1);
    check_all(2, "R4 R5 R9 distinct markers");
    check("R1 first beat after reset is marker start", {rec_st0[0], rec_am[0]}, 2'b11);

    // Phase C: output stalls every third cycle (R8 R2)
    do_reset();
    stall_mode = 1'b1;
    run_cws(4, 1'b0);
    stall_mode = 1'b0;
    check_all(4, "R8 R2 under back-pressure");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule